// File: doc/BRIEF.md
# Timer Pin Input/Output and Capture Interrupt Controller

This block controls the single external pin of one timer channel. A mode word selects what the pin does. It can be a general-purpose output that drives low or high, or releases the line in open-drain style. It can be an input whose level software reads back. It can also be an input-capture source. In that case a chosen edge of the pin copies the value of an external free-running counter into a capture register and raises an interrupt flag.

The pin passes through a synchronizer before the edge detector sees it. Interrupt flags are cleared by writing ones to them. The interrupt line is the OR of the flags, gated by an enable bit in the mode word. When a capture edge is selected, the pin is held as an input and GPIO output requests do not reach it.

Top module: `timer_pin_ctrl`

## Requirements
- R1: After reset the mode word, the status flags and the capture register read as zero, `pin_oe` is low and `irq` is low.
- R2: Writing the mode word at address 0 stores these fields: mode select in bits 2:0, GPIO control in bits 5:4, interrupt enable in bit 8, open-drain select in bit 9 and edge select in bits 17:16. All other bits read back as zero.
- R3: Status bit 8, read at address 1, gives the pin level through a two-flop synchronizer. A change on `pin_in` is visible after the second rising clock edge and not after the first.
- R4: When the mode select is 1 (input capture), a qualifying edge latches `count_in` into the capture register (read at address 2, zero-extended). It also sets status bit 0. Edge select 01 takes rising edges, 10 takes falling edges, 11 takes both and 00 takes neither. The value latched is the one on `count_in` at the clock edge two cycles after the first rising clock edge that sees the pin change.
- R5: An edge the edge select does not allow, or any edge while the mode select is not 1, leaves the capture register and status bits 3:0 unchanged.
- R6: Writing the status word at address 1 clears each flag in bits 3:0 whose written bit is 1 and leaves the others as they are. If a capture sets bit 0 in the same cycle as a write that clears it, the flag ends up set.
- R7: `irq` is high exactly when mode bit 8 is 1 and at least one of status bits 3:0 is 1.
- R8: With mode select 4 (GPIO) and GPIO control 1x, the pin is driven to the level in bit 4. GPIO control 0x, or any other mode select, leaves `pin_oe` low.
- R9: With open-drain select set, a high request leaves `pin_oe` low, and a low request drives `pin_oe` high with `pin_out` low. `pin_out` is low whenever `pin_oe` is low.
- R10: While the edge select is non-zero, `pin_oe` stays low whatever the mode select and GPIO control hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 status, 2 capture |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `reg_addr`, combinational |
| count_in | input | 16 | External free-running counter value |
| pin_in | input | 1 | Pin level from the pad |
| pin_out | output | 1 | Level driven onto the pin |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act on status bit 0 in the same cycle: a capture edge sets it, and a write-one-to-clear removes it. The bench moves the pin and counts the synchronizer and edge-detect registers. It then places the clearing write exactly on the clock edge where the capture lands. The flag must read back set and the capture register must hold the new counter value. A second clearing write with no edge pending must then drop the flag, which shows that the clear path itself works.

// File: rtl/timer_pin_pkg.sv
package timer_pin_pkg;

  localparam int REG_W = 32;

  localparam logic [2:0] MS_OFF     = 3'd0;
  localparam logic [2:0] MS_CAPTURE = 3'd1;
  localparam logic [2:0] MS_COMPARE = 3'd2;
  localparam logic [2:0] MS_PWM     = 3'd3;
  localparam logic [2:0] MS_GPIO    = 3'd4;

  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_CAPT   = 2'd2;

  localparam int LEVEL_BIT = 8;

  typedef struct packed {
    logic [1:0] edge_sel;
    logic       open_drain;
    logic       irq_en;
    logic [1:0] gpio_ctl;
    logic [2:0] sel;
  } mode_t;

  function automatic mode_t mode_from_word(input logic [REG_W-1:0] w);
    mode_t m;
    m.sel        = w[2:0];
    m.gpio_ctl   = w[5:4];
    m.irq_en     = w[8];
    m.open_drain = w[9];
    m.edge_sel   = w[17:16];
    return m;
  endfunction

  function automatic logic [REG_W-1:0] mode_to_word(input mode_t m);
    logic [REG_W-1:0] w;
    w        = '0;
    w[2:0]   = m.sel;
    w[5:4]   = m.gpio_ctl;
    w[8]     = m.irq_en;
    w[9]     = m.open_drain;
    w[17:16] = m.edge_sel;
    return w;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q,  prev_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = pin_in;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], pin_in};
    end
  endgenerate

  always_comb begin
    prev_d = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~prev_q;
  assign fall  = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/pin_capture.sv
module pin_capture #(
  parameter int CNT_W  = 16,
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [1:0]        edge_sel,
  input  logic              rise,
  input  logic              fall,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              clr_en,
  input  logic [FLAG_W-1:0] clr_mask,
  output logic [FLAG_W-1:0] flags,
  output logic [CNT_W-1:0]  cap_value,
  output logic              cap_evt
);

  logic [CNT_W-1:0]  cap_q,   cap_d;
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic [FLAG_W-1:0] set_vec;

  always_comb begin
    cap_evt = arm & ((edge_sel[0] & rise) | (edge_sel[1] & fall));
    cap_d   = cap_evt ? count_in : cap_q;
  end

  genvar gi;
  generate
    for (gi = 0; gi < FLAG_W; gi++) begin : g_flag
      if (gi == 0) begin : g_src
        assign set_vec[gi] = cap_evt;
      end else begin : g_nosrc
        assign set_vec[gi] = 1'b0;
      end
      always_comb begin
        flags_d[gi] = (flags_q[gi] & ~(clr_en & clr_mask[gi])) | set_vec[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      flags_q <= '0;
    end else begin
      cap_q   <= cap_d;
      flags_q <= flags_d;
    end
  end

  assign flags     = flags_q;
  assign cap_value = cap_q;

endmodule

// File: rtl/pin_drive.sv
module pin_drive
  import timer_pin_pkg::*;
(
  input  mode_t mode,
  output logic  pin_out,
  output logic  pin_oe
);

  logic want_drive;
  logic input_only;

  always_comb begin
    input_only = (mode.edge_sel != 2'b00);
    want_drive = (mode.sel == MS_GPIO) && mode.gpio_ctl[1] && !input_only;
    pin_oe     = want_drive && !(mode.open_drain && mode.gpio_ctl[0]);
    pin_out    = pin_oe && mode.gpio_ctl[0] && !mode.open_drain;
  end

endmodule

// File: rtl/timer_pin_ctrl.sv
module timer_pin_ctrl
  import timer_pin_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int FLAG_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic [CNT_W-1:0] count_in,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             irq
);

  localparam int PAD_W = REG_W - CNT_W;

  logic [1:0]        rst_pipe_q, rst_pipe_d;
  logic              rst_sync_n;
  mode_t             mode_q, mode_d;
  logic              level, rise, fall;
  logic [FLAG_W-1:0] flags;
  logic [CNT_W-1:0]  cap_value;
  logic              cap_evt;
  logic              mode_wr, status_wr;
  logic [REG_W-1:0]  status_word;

  always_comb rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_sync_n = rst_pipe_q[1];

  always_comb begin
    mode_wr   = wr_en && (reg_addr == ADDR_MODE);
    status_wr = wr_en && (reg_addr == ADDR_STATUS);
    mode_d    = mode_wr ? mode_from_word(wr_data) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mode_q <= '0;
    else             mode_q <= mode_d;
  end

  pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_in (pin_in),
    .level  (level),
    .rise   (rise),
    .fall   (fall)
  );

  pin_capture #(.CNT_W(CNT_W), .FLAG_W(FLAG_W)) u_capt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .arm       (mode_q.sel == MS_CAPTURE),
    .edge_sel  (mode_q.edge_sel),
    .rise      (rise),
    .fall      (fall),
    .count_in  (count_in),
    .clr_en    (status_wr),
    .clr_mask  (wr_data[FLAG_W-1:0]),
    .flags     (flags),
    .cap_value (cap_value),
    .cap_evt   (cap_evt)
  );

  pin_drive u_drive (
    .mode    (mode_q),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  always_comb begin
    status_word                = '0;
    status_word[FLAG_W-1:0]    = flags;
    status_word[LEVEL_BIT]     = level;
    case (reg_addr)
      ADDR_MODE:   rd_data = mode_to_word(mode_q);
      ADDR_STATUS: rd_data = status_word;
      ADDR_CAPT:   rd_data = {{PAD_W{1'b0}}, cap_value};
      default:     rd_data = '0;
    endcase
    irq = mode_q.irq_en && (|flags);
  end

endmodule

// File: rtl/timer_pin_ctrl_chk.sv
module timer_pin_ctrl_chk
  import timer_pin_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FLAG_W = 4
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [1:0]        reg_addr,
  input logic [31:0]       wr_data,
  input mode_t             mode_q,
  input logic [FLAG_W-1:0] flags,
  input logic [CNT_W-1:0]  cap_value,
  input logic              cap_evt,
  input logic              pin_out,
  input logic              pin_oe,
  input logic              irq
);

  assert_capture_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(cap_value) |-> flags[0]);

  assert_clear_wins_alone_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && reg_addr == ADDR_STATUS && wr_data[0] && !cap_evt) |=> !flags[0]);

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq) |-> (mode_q.irq_en && flags != '0));

  assert_drive_mode_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pin_oe |-> (mode_q.sel == MS_GPIO && mode_q.gpio_ctl[1]));

  assert_open_drain_low_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pin_oe && mode_q.open_drain) |-> !pin_out);

  assert_input_only_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q.edge_sel != 2'b00) |-> !pin_oe);

endmodule

bind timer_pin_ctrl timer_pin_ctrl_chk #(.CNT_W(CNT_W), .FLAG_W(FLAG_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .reg_addr   (reg_addr),
  .wr_data    (wr_data),
  .mode_q     (mode_q),
  .flags      (flags),
  .cap_value  (cap_value),
  .cap_evt    (cap_evt),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .irq        (irq)
);

// File: tb/timer_pin_ctrl_test.sv
`timescale 1ns/1ps
module timer_pin_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  reg_addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [15:0] count_in;
  logic        pin_in;
  logic        pin_out;
  logic        pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  timer_pin_ctrl uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .count_in (count_in),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .irq      (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] rv;
    logic [15:0] exp_cap;
    int idx;
    rst_n = 1'b0; wr_en = 1'b0; reg_addr = '0; wr_data = '0;
    count_in = '0; pin_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(4);

    // R1: reset state
    bus_read(2'd0, rv); check("R1 mode", rv, 32'h0);
    bus_read(2'd1, rv); check("R1 status", rv, 32'h0);
    bus_read(2'd2, rv); check("R1 capture", rv, 32'h0);
    check("R1 oe", {31'b0, pin_oe}, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 and R10: all-ones mode write keeps only defined fields
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read(2'd0, rv); check("R2 readback", rv, 32'h0003_0337);
    check("R10 oe with edge set", {31'b0, pin_oe}, 32'h0);

    // R8 R9 R10: output sweep
    for (int ms = 0; ms < 8; ms++)
      for (int g = 0; g < 4; g++)
        for (int od = 0; od < 2; od++)
          for (int e = 0; e < 4; e += 2) begin
            logic [31:0] w;
            logic exp_oe, exp_out;
            w = ms | (g << 4) | (od << 9) | (e << 16);
            bus_write(2'd0, w);
            exp_oe  = (ms == 4) && g[1] && (e == 0) && !(od == 1 && g[0]);
            exp_out = exp_oe && g[0] && (od == 0);
            bus_read(2'd0, rv); check("R2 field readback", rv, w);
            check("R8 R9 R10 oe", {31'b0, pin_oe}, {31'b0, exp_oe});
            check("R8 R9 out", {31'b0, pin_out}, {31'b0, exp_out});
          end

    // R3: synchronizer latency
    bus_write(2'd0, 32'h0);
    pin_in = 1'b1;
    tick(1);
    bus_read(2'd1, rv); check("R3 level after one edge", {31'b0, rv[8]}, 32'h0);
    tick(1);
    bus_read(2'd1, rv); check("R3 level after two edges", {31'b0, rv[8]}, 32'h1);
    pin_in = 1'b0;
    tick(4);

    // R4 R5 R7: capture sweep
    exp_cap = 16'h0;
    idx = 0;
    for (int es = 0; es < 4; es++)
      for (int armed = 0; armed < 2; armed++)
        for (int dir = 0; dir < 2; dir++) begin
          logic start, hit, ien;
          logic [31:0] w;
          start = (dir == 1);
          ien   = ((es + dir) % 2) == 1;
          bus_write(2'd0, 32'h0);
          pin_in = start;
          tick(4);
          w = (armed ? 1 : 4) | (ien << 8) | (es << 16);
          bus_write(2'd0, w);
          bus_write(2'd1, 32'hF);
          count_in = 16'hA000 + 16'(idx);
          pin_in = ~start;
          tick(3);
          hit = armed && ((dir == 0) ? es[0] : es[1]);
          if (hit) exp_cap = count_in;
          bus_read(2'd1, rv);
          check(hit ? "R4 flag set" : "R5 flag unchanged", {31'b0, rv[0]}, {31'b0, hit});
          check("R3 level", {31'b0, rv[8]}, {31'b0, ~start});
          bus_read(2'd2, rv);
          check(hit ? "R4 capture value" : "R5 capture kept", rv, {16'h0, exp_cap});
          check("R7 irq", {31'b0, irq}, {31'b0, ien && hit});
          idx++;
        end

    // R6: write-one-to-clear, zeros ignored, set beats clear
    bus_write(2'd0, 32'h0001_0101);
    pin_in = 1'b0;
    tick(4);
    bus_write(2'd1, 32'hF);
    count_in = 16'h5A5A;
    pin_in = 1'b1;
    tick(3);
    bus_read(2'd1, rv); check("R6 flag set before clear", {31'b0, rv[0]}, 32'h1);
    bus_write(2'd1, 32'hE);
    bus_read(2'd1, rv); check("R6 zero bit keeps flag", {31'b0, rv[0]}, 32'h1);
    check("R7 irq while flagged", {31'b0, irq}, 32'h1);
    bus_write(2'd1, 32'h1);
    bus_read(2'd1, rv); check("R6 one bit clears flag", {31'b0, rv[0]}, 32'h0);
    check("R7 irq after clear", {31'b0, irq}, 32'h0);
    pin_in = 1'b0;
    tick(4);
    count_in = 16'h1234;
    pin_in = 1'b1;
    tick(2);
    wr_en = 1'b1; reg_addr = 2'd1; wr_data = 32'h1;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
    bus_read(2'd1, rv); check("R6 set wins over clear", {31'b0, rv[0]}, 32'h1);
    bus_read(2'd2, rv); check("R6 R4 capture in collision", rv, 32'h0000_1234);
    bus_write(2'd1, 32'h1);
    bus_read(2'd1, rv); check("R6 later clear", {31'b0, rv[0]}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule